// File: doc/BRIEF.md
# Zero-Phase-Start Clock Switching Sequencer

This block coordinates the hand-over of a recovered clock between two sources: a stable reference clock and a startable/stoppable oscillator. It is used when a read-mode gate changes. The gate arrives with no timing relationship to the block's sampling clock, so it is first brought into that domain. Each change of the synchronized gate starts a zero-phase-start routine. The oscillator runs a fixed number of complete cycles and is then held stopped and low. It restarts in phase with a chosen alignment event: the second data pulse in read mode, or the second reference rising edge in reference mode. When the restart happens, a done flag is raised.

All clock-like signals are represented as levels sampled by one fast clock `clk`. The oscillator is a behavioural gated source inside the block. The output clock comes from a glitch-free selector built from two cross-coupled enable flops. Each flop changes only on the falling edge of its own source, so one source is fully disabled before the other is enabled. The output carries the reference clock in reference mode and during any sequence. It carries the oscillator only once a read-mode sequence has completed.

If the gate changes part-way through a sequence, the block abandons that sequence. It starts a new one for the new mode with the oscillator running, so the oscillator is never left stopped.

Top module: `zps_clock_sequencer`

## Requirements
- R1: `read_gate_in` passes through SYNC_STAGES (default 2) flops. A change applied before clock edge k is acted on at edge k+SYNC_STAGES: `zps_done` reads low after that edge and not before it.
- R2: After each mode change the oscillator completes PAUSE_CYCLES (default 2) full cycles. On the falling edge that ends the last of these cycles, `osc_stop` goes high, and `osc_clk` then stays low while `osc_stop` is high.
- R3: While stopped, the oscillator waits for ALIGN_EDGE (default 2) alignment events. On the edge after the last of them, `osc_stop` falls and `zps_done` rises, and `osc_clk` rises one clock later. A running oscillator is high for the first OSC_PERIOD/2 cycles of each OSC_PERIOD-cycle period.
- R4: While the synchronized gate is low (reference mode), `clk_out` carries the synchronized reference level, registered once.
- R5: `clk_out` carries the oscillator only after a read-mode sequence has finished. It follows `osc_clk` one clock later once the enable hand-over has settled.
- R6: In reference mode, the alignment events are rising edges of `ref_clk_in`. In read mode, they are rising edges of `data_in`.
- R7: The two source enables are never both on, and no high pulse on `clk_out` is shorter than MIN_PULSE clocks.
- R8: `zps_done` is high from the restart until the synchronized gate changes. It is low from the edge after that change until the next restart, and it is high out of reset.
- R9: A gate change while the oscillator is stopped releases `osc_stop` on the same edge that restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_gate_in | input | 1 | Asynchronous read-mode gate, high selects read mode |
| ref_clk_in | input | 1 | Reference clock level, sampled |
| data_in | input | 1 | Encoded data pulses, rising edge is an event |
| osc_clk | output | 1 | Behavioural oscillator output |
| osc_stop | output | 1 | High while the oscillator is held stopped |
| clk_out | output | 1 | Glitch-free selected output clock |
| zps_done | output | 1 | High once the zero-phase-start routine has finished |

## Verification
Several properties are checked on every cycle:
- the two source enables never overlap, and no short high pulse reaches the output;
- a halt begins only on an oscillator falling edge, and a restart follows only an alignment event;
- the oscillator stays low while halted and rises on the edge after release;
- a synchronized gate change always clears the done flag and lifts any halt.

Whole-sequence behaviour needs the bench's scenarios:
- the exact synchronizer latency;
- which source supplies the alignment events in each mode;
- the output following the oscillator after a read sequence;
- an abort from the stopped state.

// File: rtl/zps_pkg.sv
package zps_pkg;

  typedef enum logic [1:0] {
    PH_COUNT = 2'd0,
    PH_HALT  = 2'd1,
    PH_DONE  = 2'd2
  } zps_phase_e;

  // Oscillator level for a given position inside its period.
  function automatic logic osc_high(input int unsigned pos, input int unsigned period);
    return pos < (period / 2);
  endfunction

  // Next position inside the oscillator period, wrapping to zero.
  function automatic int unsigned osc_step(input int unsigned pos, input int unsigned period);
    return (pos + 1 >= period) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/zps_sync.sv
module zps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '0;
      q_prev <= 1'b0;
    end else begin
      pipe   <= {pipe[STAGES-2:0], d};
      q_prev <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/zps_osc_src.sv
module zps_osc_src
  import zps_pkg::*;
#(
  parameter int PERIOD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic lvl,
  output logic fall
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] pos;
  logic          lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      lvl      <= 1'b0;
      lvl_prev <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      if (halt) begin
        pos <= '0;
        lvl <= 1'b0;
      end else begin
        lvl <= osc_high(32'(pos), PERIOD);
        pos <= CW'(osc_step(32'(pos), PERIOD));
      end
    end
  end

  assign fall = lvl_prev & ~lvl;

  // R2: a halted oscillator stays low
  assert_stopped_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt)) |-> !lvl)
    else $error("oscillator high while halted");

  // R3: release from halt gives a rising oscillator one clock later
  assert_restart_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |=> lvl)
    else $error("oscillator not restarted high");
endmodule

// File: rtl/zps_seq_fsm.sv
module zps_seq_fsm
  import zps_pkg::*;
#(
  parameter int PAUSE_CYCLES = 2,
  parameter int ALIGN_EDGE   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_s,
  input  logic osc_fall,
  input  logic data_edge,
  input  logic ref_rise,
  output logic mode,
  output logic mode_chg,
  output logic halted,
  output logic done
);
  localparam int MAXN = (PAUSE_CYCLES > ALIGN_EDGE) ? PAUSE_CYCLES : ALIGN_EDGE;
  localparam int NW   = $clog2(MAXN + 1);

  zps_phase_e      phase;
  logic [NW-1:0]   n;
  logic            align;

  assign mode_chg = gate_s != mode;
  assign align    = mode ? data_edge : ref_rise;
  assign halted   = phase == PH_HALT;
  assign done     = phase == PH_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 1'b0;
      phase <= PH_DONE;
      n     <= '0;
    end else if (mode_chg) begin
      mode  <= gate_s;
      phase <= PH_COUNT;
      n     <= '0;
    end else begin
      case (phase)
        PH_COUNT: if (osc_fall) begin
          if (n == NW'(PAUSE_CYCLES - 1)) begin
            phase <= PH_HALT;
            n     <= '0;
          end else begin
            n <= n + 1'b1;
          end
        end
        PH_HALT: if (align) begin
          if (n == NW'(ALIGN_EDGE - 1)) begin
            phase <= PH_DONE;
            n     <= '0;
          end else begin
            n <= n + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: halting begins only right after an oscillator falling edge
  assert_halt_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(osc_fall))
    else $error("halt without oscillator fall");

  // R3 / R6: completion follows an alignment event of the current mode
  assert_done_on_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(align))
    else $error("restart without alignment event");

  // R8: a gate change clears the done flag
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !done)
    else $error("done kept after gate change");

  // R9: an abort never leaves the oscillator halted
  assert_abort_resumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mode_chg) |=> !halted)
    else $error("oscillator left halted after abort");
endmodule

// File: rtl/zps_clk_mux.sv
module zps_clk_mux #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_osc,
  input  logic ref_lvl,
  input  logic ref_fall,
  input  logic osc_lvl,
  input  logic osc_fall,
  output logic clk_out
);
  localparam int RW = $clog2(MIN_PULSE + 1) + 1;

  logic          ref_en;
  logic          osc_en;
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_en  <= 1'b1;
      osc_en  <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      if (ref_fall) ref_en <= ~want_osc & ~osc_en;
      if (osc_fall) osc_en <= want_osc & ~ref_en;
      clk_out <= (ref_lvl & ref_en) | (osc_lvl & osc_en);
    end
  end

  // length of the current high run on the output, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_run <= '0;
    else if (!clk_out)     hi_run <= '0;
    else if (hi_run < RW'(MIN_PULSE)) hi_run <= hi_run + 1'b1;
  end

  // R7: break-before-make between the two sources
  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_en && osc_en))
    else $error("both sources enabled");

  // R7: no runt high pulse on the output
  assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_out && hi_run != '0) |-> hi_run >= RW'(MIN_PULSE))
    else $error("runt pulse on output clock");

  // R5: oscillator path opens only when requested
  assert_osc_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(want_osc))
    else $error("oscillator enabled without request");

  // R4: reference path reopens only when the oscillator is not wanted
  assert_ref_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> !$past(want_osc))
    else $error("reference enabled while oscillator wanted");
endmodule

// File: rtl/zps_clock_sequencer.sv
module zps_clock_sequencer #(
  parameter int SYNC_STAGES  = 2,
  parameter int OSC_PERIOD   = 6,
  parameter int PAUSE_CYCLES = 2,
  parameter int ALIGN_EDGE   = 2,
  parameter int MIN_PULSE    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_gate_in,
  input  logic ref_clk_in,
  input  logic data_in,
  output logic osc_clk,
  output logic osc_stop,
  output logic clk_out,
  output logic zps_done
);
  logic gate_s, gate_p;
  logic data_s, data_p;
  logic ref_s, ref_p;
  logic data_edge, ref_rise, ref_fall;
  logic osc_fall;
  logic mode, mode_chg, halted, done;
  logic want_osc;

  zps_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(read_gate_in), .q(gate_s), .q_prev(gate_p));
  zps_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_s), .q_prev(data_p));
  zps_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .d(ref_clk_in), .q(ref_s), .q_prev(ref_p));

  assign data_edge = data_s & ~data_p;
  assign ref_rise  = ref_s & ~ref_p;
  assign ref_fall  = ~ref_s & ref_p;

  zps_seq_fsm #(.PAUSE_CYCLES(PAUSE_CYCLES), .ALIGN_EDGE(ALIGN_EDGE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .gate_s(gate_s), .osc_fall(osc_fall),
    .data_edge(data_edge), .ref_rise(ref_rise),
    .mode(mode), .mode_chg(mode_chg), .halted(halted), .done(done));

  zps_osc_src #(.PERIOD(OSC_PERIOD)) u_osc (
    .clk(clk), .rst_n(rst_n), .halt(halted), .lvl(osc_clk), .fall(osc_fall));

  assign want_osc = mode & done;

  zps_clk_mux #(.MIN_PULSE(MIN_PULSE)) u_mux (
    .clk(clk), .rst_n(rst_n), .want_osc(want_osc),
    .ref_lvl(ref_s), .ref_fall(ref_fall),
    .osc_lvl(osc_clk), .osc_fall(osc_fall), .clk_out(clk_out));

  assign osc_stop = halted;
  assign zps_done = done;

  // R1: every synchronized gate edge starts a new sequence
  assert_gate_edge_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s ^ gate_p) |-> mode_chg)
    else $error("synchronized gate edge not acted on");
endmodule

// File: tb/zps_clock_sequencer_bench.sv
module zps_clock_sequencer_bench;
  localparam int PER   = 6;
  localparam int PAUSE = 2;
  localparam int ALIGN = 2;
  localparam int MINP  = 3;
  localparam int REF_HALF = 4;
  localparam int DATA_GAP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic read_gate_in = 1'b0;
  logic ref_clk_in = 1'b0;
  logic data_in = 1'b0;
  logic osc_clk, osc_stop, clk_out, zps_done;

  int checks = 0;
  int fails = 0;
  bit data_on = 1'b0;

  always #10 clk = ~clk;

  zps_clock_sequencer #(.SYNC_STAGES(2), .OSC_PERIOD(PER), .PAUSE_CYCLES(PAUSE),
                        .ALIGN_EDGE(ALIGN), .MIN_PULSE(MINP)) u_zps_clock_sequencer (
    .clk(clk), .rst_n(rst_n), .read_gate_in(read_gate_in), .ref_clk_in(ref_clk_in),
    .data_in(data_in), .osc_clk(osc_clk), .osc_stop(osc_stop),
    .clk_out(clk_out), .zps_done(zps_done));

  // stimulus sources, driven away from the active edge
  int ref_cnt = 0;
  always @(negedge clk) begin
    ref_cnt = ref_cnt + 1;
    if (ref_cnt == REF_HALF) begin ref_cnt = 0; ref_clk_in = ~ref_clk_in; end
  end

  int data_cnt = 0;
  always @(negedge clk) begin
    data_cnt = (data_cnt + 1) % DATA_GAP;
    data_in = data_on && (data_cnt < 2);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model: delay lines, event counters and a phase number
  bit gate_dl[$], data_dl[$], ref_dl[$];
  bit m_dprev, m_rprev, m_mode, m_oq, m_oprev, m_ren, m_oen, m_out;
  int m_phase;   // 0 running-before-halt, 1 halted, 2 finished
  int m_events, m_opos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_dl = '{0, 0}; data_dl = '{0, 0}; ref_dl = '{0, 0};
      m_dprev = 0; m_rprev = 0; m_mode = 0; m_oq = 0; m_oprev = 0;
      m_ren = 1; m_oen = 0; m_out = 0; m_phase = 2; m_events = 0; m_opos = 0;
    end else begin
      bit gs, ds, rs, dev, rup, rdn, odn, want, alg, nren, noen;
      gs = gate_dl[0]; ds = data_dl[0]; rs = ref_dl[0];
      dev = ds && !m_dprev; rup = rs && !m_rprev; rdn = !rs && m_rprev;
      odn = m_oprev && !m_oq;
      want = m_mode && (m_phase == 2);
      alg = m_mode ? dev : rup;
      m_out = (rs && m_ren) || (m_oq && m_oen);
      nren = rdn ? (!want && !m_oen) : m_ren;
      noen = odn ? (want && !m_ren) : m_oen;
      m_ren = nren; m_oen = noen;
      m_oprev = m_oq;
      if (m_phase == 1) begin m_opos = 0; m_oq = 0; end
      else begin m_oq = (m_opos < PER / 2); m_opos = (m_opos + 1) % PER; end
      if (gs != m_mode) begin
        m_mode = gs; m_phase = 0; m_events = 0;
      end else if (m_phase == 0 && odn) begin
        m_events++;
        if (m_events == PAUSE) begin m_phase = 1; m_events = 0; end
      end else if (m_phase == 1 && alg) begin
        m_events++;
        if (m_events == ALIGN) begin m_phase = 2; m_events = 0; end
      end
      m_dprev = ds; m_rprev = rs;
      void'(gate_dl.pop_front()); gate_dl.push_back(read_gate_in);
      void'(data_dl.pop_front()); data_dl.push_back(data_in);
      void'(ref_dl.pop_front());  ref_dl.push_back(ref_clk_in);
    end
  end

  // every-cycle comparison and runt watch on the output
  int hi_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "osc_stop", osc_stop, m_phase == 1);
      check("R3", "osc_clk", osc_clk, m_oq);
      check("R8", "zps_done", zps_done, m_phase == 2);
      check(m_mode ? "R5" : "R4", "clk_out", clk_out, m_out);
      if (clk_out) hi_len++;
      else begin
        if (hi_len != 0) check("R7", "output high pulse >= MIN", hi_len >= MINP, 1);
        hi_len = 0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  // wait for the current sequence to finish, returning the halted cycle count
  task automatic wait_done(output int halt_cycles);
    halt_cycles = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2000 && !zps_done; i++) begin
      if (osc_stop) halt_cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hc;
    bit prev_osc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "done out of reset", zps_done, 1);
    check("R2", "running out of reset", osc_stop, 0);
    check("R4", "clk_out reset", clk_out, 0);
    data_on = 1'b1;
    repeat (30) @(negedge clk);

    // R1: two-stage latency on the gate
    read_gate_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "done held before sync latency", zps_done, 1);
    @(negedge clk);
    check("R1", "done dropped after sync latency", zps_done, 0);

    // R3 / R6: read sequence aligned to data pulses
    for (int i = 0; i < 2000 && !zps_done; i++) begin
      if (osc_stop) hc++;
      @(negedge clk);
    end
    check("R3", "osc low at restart", osc_clk, 0);
    check("R6", "halted before read restart", hc > 0, 1);
    @(negedge clk);
    check("R3", "osc high after restart", osc_clk, 1);

    // R5: output follows the oscillator once settled
    repeat (40) @(negedge clk);
    prev_osc = osc_clk;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R5", "clk_out follows osc", clk_out, prev_osc);
      prev_osc = osc_clk;
    end

    // R6: back to reference, aligned to reference rising edges
    read_gate_in = 1'b0;
    wait_done(hc);
    check("R6", "halted during reference sequence", hc > 0, 1);
    check("R8", "done after reference sequence", zps_done, 1);
    repeat (60) @(negedge clk);

    // R9: abort while halted in read mode with no data pulses
    data_on = 1'b0;
    repeat (3) @(negedge clk);
    read_gate_in = 1'b1;
    for (int i = 0; i < 200 && !osc_stop; i++) @(negedge clk);
    check("R9", "halted awaiting data", osc_stop, 1);
    repeat (5) @(negedge clk);
    read_gate_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "still halted inside sync latency", osc_stop, 1);
    @(negedge clk);
    check("R9", "halt released on abort", osc_stop, 0);
    wait_done(hc);
    check("R9", "reference sequence completes after abort", zps_done, 1);
    data_on = 1'b1;
    repeat (60) @(negedge clk);

    summary();
    $finish;
  end
endmodule